// File: doc/BRIEF.md
# Output Channel Accumulation Buffer

This block keeps the running partial sums of one output pixel while a convolution engine steps through all of its input channels. Each output channel owns one entry. A result arriving with the first-input-channel flag set replaces its entry. Any other result is added to what the entry already holds. Because of this, nothing has to clear the buffer between pixels. Values are signed fixed point, two's complement, of a parameterised width.

The entries are spread cyclically over `N_PE` banks, one bank per processing element. The update port therefore carries one row address and one value per lane, and `N_PE` consecutive channels can be updated in the same cycle. Each bank has a two-cycle read latency. An update is read, summed and written back over three pipeline stages. Results that are still on their way to memory are forwarded to later updates, so back-to-back updates of the same entry are not lost.

Once the input-channel loop is finished, a drain request writes the first N entries out in ascending channel order. This goes through a valid/ready write port, and each address is a base plus the channel number. A one-cycle done pulse closes the drain.

Top module: `oacc_buffer`

## Requirements
- R1: Channel c lives in lane c mod N_PE at row c div N_PE. An update on row r carries, for every lane g whose bit g of `upd_lane_en` is set, the value for channel r*N_PE+g in bits [g*DATA_W +: DATA_W] of `upd_data`.
- R2: An enabled lane of an update with `upd_first` high stores its value into the entry, and the old contents are discarded.
- R3: An enabled lane of an update with `upd_first` low stores the old entry plus the value, wrapping modulo 2^DATA_W (for example 0x7FFF + 1 gives 0x8000).
- R4: Updates may be issued in consecutive cycles, including several to the same row. The final contents equal those from applying every update in issue order. An update is settled three cycles after it is issued.
- R5: An entry whose lane bit is clear in an update keeps its value, and so does any entry of a row that is not addressed.
- R6: A drain started with count n writes min(n, MAX_CH) beats for channels 0, 1, … in ascending order. Each beat has `wr_addr` = `drain_base` + channel and `wr_data` = that entry's value.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged.
- R8: `drain_done` is high for exactly one cycle: the cycle after the last beat is accepted. With a count of zero it is high in the cycle after `drain_start`, and no beat is written.
- R9: After reset `wr_valid` and `drain_done` are low.
- R10: The caller starts a drain only after three idle update cycles and issues no update while a drain is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid | input | 1 | Update present this cycle |
| upd_row | input | ROW_W | Row (channel group) being updated |
| upd_lane_en | input | N_PE | Per-lane update enable |
| upd_first | input | 1 | First input channel: overwrite instead of add |
| upd_data | input | N_PE*DATA_W | Per-lane signed results |
| drain_start | input | 1 | Begin writing entries out |
| drain_count | input | CNT_W | Number of channels to write |
| drain_base | input | ADDR_W | Address of channel 0 |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Entry value |
| drain_done | output | 1 | One-cycle end-of-drain pulse |

## Verification
The bench targets the forwarding hazards: same-row updates at spacings of zero, one and two cycles. A design that missed a forward would drop one of the two additions, and the drained entry would come out short. Partial lane masks test for a design that writes disabled lanes, which would corrupt a neighbouring channel. Ready stalls test for a drain that advances or changes its data while stalled. A count of zero tests for a drain that hangs or emits a stray beat. A count above the depth tests for a drain that reads past the last row. The 0x7FFF + 1 case exposes any saturating or width-losing adder.

// File: rtl/oacc_pkg.sv
package oacc_pkg;
  typedef enum logic [2:0] {
    DR_IDLE,
    DR_ISSUE,
    DR_WAIT,
    DR_SHOW,
    DR_DONE
  } drain_state_e;
endpackage

// File: rtl/oacc_bank.sv
module oacc_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_W-1:0]  ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ROW_W-1:0]  rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ra_q1, rb_q1;

  // two-cycle read latency on both read ports
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_q1   <= mem[ra_addr];
    ra_data <= ra_q1;
    rb_q1   <= mem[rb_addr];
    rb_data <= rb_q1;
  end
endmodule

// File: rtl/oacc_lane.sv
module oacc_lane #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en,
  input  logic              in_first,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data
);
  function automatic logic [DATA_W-1:0] merge_val(input logic [DATA_W-1:0] old_v,
                                                  input logic [DATA_W-1:0] add_v,
                                                  input logic first);
    return first ? add_v : old_v + add_v;
  endfunction

  logic              p1_en, p2_en, w1_en, w2_en;
  logic              p1_first, p2_first;
  logic [ROW_W-1:0]  p1_row, p2_row, w1_row, w2_row;
  logic [DATA_W-1:0] p1_data, p2_data, w1_val, w2_val;
  logic [DATA_W-1:0] mem_old, old_val, new_val;

  oacc_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ROW_W(ROW_W)) bank_i (
    .clk(clk), .we(p2_en), .waddr(p2_row), .wdata(new_val),
    .ra_addr(in_row), .ra_data(mem_old),
    .rb_addr(rd_row), .rb_data(rd_data)
  );

  // w1: written at the last edge, w2: the edge before; the read missed both
  always_comb begin
    if (w1_en && w1_row == p2_row)      old_val = w1_val;
    else if (w2_en && w2_row == p2_row) old_val = w2_val;
    else                                old_val = mem_old;
    new_val = merge_val(old_val, p2_data, p2_first);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_en <= 1'b0;
      p2_en <= 1'b0;
      w1_en <= 1'b0;
      w2_en <= 1'b0;
    end else begin
      p1_en <= in_en;
      p2_en <= p1_en;
      w1_en <= p2_en;
      w2_en <= w1_en;
    end
  end

  always_ff @(posedge clk) begin
    p1_first <= in_first;
    p1_row   <= in_row;
    p1_data  <= in_data;
    p2_first <= p1_first;
    p2_row   <= p1_row;
    p2_data  <= p1_data;
    w1_row   <= p2_row;
    w1_val   <= new_val;
    w2_row   <= w1_row;
    w2_val   <= w1_val;
  end
endmodule

// File: rtl/oacc_drain.sv
module oacc_drain
  import oacc_pkg::*;
#(
  parameter int N_PE   = 4,
  parameter int MAX_CH = 64,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 4,
  parameter int CH_W   = 6,
  parameter int CNT_W  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNT_W-1:0]       count,
  input  logic [ADDR_W-1:0]      base,
  input  logic [N_PE*DATA_W-1:0] lane_rd,
  output logic [ROW_W-1:0]       rd_row,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [DATA_W-1:0]      wr_data,
  output logic                   done
);
  function automatic logic [ROW_W-1:0] chan_row(input logic [CH_W-1:0] c);
    return ROW_W'(c / CH_W'(N_PE));
  endfunction
  function automatic int chan_lane(input logic [CH_W-1:0] c);
    return int'(c % CH_W'(N_PE));
  endfunction
  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] n);
    return (n > CNT_W'(MAX_CH)) ? CNT_W'(MAX_CH) : n;
  endfunction

  drain_state_e      st;
  logic [CH_W-1:0]   ch;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              last_beat;

  assign rd_row    = chan_row(ch);
  assign wr_valid  = (st == DR_SHOW);
  assign wr_addr   = base_q + ADDR_W'(ch);
  assign wr_data   = lane_rd[chan_lane(ch)*DATA_W +: DATA_W];
  assign done      = (st == DR_DONE);
  assign last_beat = (CNT_W'(ch) + CNT_W'(1)) == cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= DR_IDLE;
      ch     <= '0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      case (st)
        DR_IDLE: if (start) begin
          ch     <= '0;
          cnt_q  <= clamp_cnt(count);
          base_q <= base;
          st     <= (count == '0) ? DR_DONE : DR_ISSUE;
        end
        DR_ISSUE: st <= DR_WAIT;
        DR_WAIT:  st <= DR_SHOW;
        DR_SHOW: if (wr_ready) begin
          if (last_beat) st <= DR_DONE;
          else begin
            ch <= ch + CH_W'(1);
            st <= DR_ISSUE;
          end
        end
        DR_DONE: st <= DR_IDLE;
        default: st <= DR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oacc_buffer.sv
module oacc_buffer #(
  parameter int N_PE   = 4,
  parameter int MAX_CH = 64,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  localparam int DEPTH = MAX_CH / N_PE,
  localparam int ROW_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CH_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
  localparam int CNT_W = $clog2(MAX_CH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_valid,
  input  logic [ROW_W-1:0]       upd_row,
  input  logic [N_PE-1:0]        upd_lane_en,
  input  logic                   upd_first,
  input  logic [N_PE*DATA_W-1:0] upd_data,
  input  logic                   drain_start,
  input  logic [CNT_W-1:0]       drain_count,
  input  logic [ADDR_W-1:0]      drain_base,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [DATA_W-1:0]      wr_data,
  output logic                   drain_done
);
  logic [ROW_W-1:0]       drain_row;
  logic [N_PE*DATA_W-1:0] lane_rd;

  for (genvar g = 0; g < N_PE; g++) begin : g_lane
    oacc_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ROW_W(ROW_W)) lane_i (
      .clk(clk), .rst_n(rst_n),
      .in_en(upd_valid & upd_lane_en[g]),
      .in_first(upd_first),
      .in_row(upd_row),
      .in_data(upd_data[g*DATA_W +: DATA_W]),
      .rd_row(drain_row),
      .rd_data(lane_rd[g*DATA_W +: DATA_W])
    );
  end

  oacc_drain #(
    .N_PE(N_PE), .MAX_CH(MAX_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ROW_W(ROW_W), .CH_W(CH_W), .CNT_W(CNT_W)
  ) drain_i (
    .clk(clk), .rst_n(rst_n),
    .start(drain_start), .count(drain_count), .base(drain_base),
    .lane_rd(lane_rd), .rd_row(drain_row),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(drain_done)
  );
endmodule

// File: rtl/oacc_buffer_chk.sv
module oacc_buffer_chk #(
  parameter int MAX_CH = 64,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic              drain_start,
  input logic [CNT_W-1:0]  drain_count,
  input logic [ADDR_W-1:0] drain_base,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              drain_done
);
  logic [ADDR_W-1:0] seen_base;
  logic [CNT_W-1:0]  seen_beats, seen_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_base  <= '0;
      seen_beats <= '0;
      seen_limit <= '0;
    end else if (drain_start && !wr_valid) begin
      seen_base  <= drain_base;
      seen_beats <= '0;
      seen_limit <= (drain_count > CNT_W'(MAX_CH)) ? CNT_W'(MAX_CH) : drain_count;
    end else if (wr_valid && wr_ready) begin
      seen_beats <= seen_beats + CNT_W'(1);
    end
  end

  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |=> !drain_done);

  a_r10_no_upd_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !upd_valid);

  a_r6_addr_order: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr == seen_base + ADDR_W'(seen_beats));

  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> seen_beats < seen_limit);
endmodule

bind oacc_buffer oacc_buffer_chk #(
  .MAX_CH(MAX_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid),
  .drain_start(drain_start), .drain_count(drain_count), .drain_base(drain_base),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .drain_done(drain_done)
);

// File: tb/oacc_buffer_tb_top.sv
module oacc_buffer_tb_top;
  localparam int NP = 4, MC = 64, DW = 16, AW = 32;
  localparam int RW = 4, CW = 7, ROWS = MC / NP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_valid = 0, upd_first = 0, drain_start = 0, wr_ready = 0;
  logic [RW-1:0] upd_row = '0;
  logic [NP-1:0] upd_lane_en = '0;
  logic [NP*DW-1:0] upd_data = '0;
  logic [CW-1:0] drain_count = '0;
  logic [AW-1:0] drain_base = '0;
  logic wr_valid, drain_done;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [DW-1:0] model [MC];

  always #10 clk = ~clk;

  oacc_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_row(upd_row),
    .upd_lane_en(upd_lane_en), .upd_first(upd_first), .upd_data(upd_data),
    .drain_start(drain_start), .drain_count(drain_count), .drain_base(drain_base),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .drain_done(drain_done)
  );

  function automatic logic [DW-1:0] expect_entry(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] v, input logic f);
    return f ? v : old_v + v;
  endfunction

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // R1 R2 R3 R5: one update; model applies lane by lane
  task automatic send(input int row, input logic [NP-1:0] m, input logic f,
                      input logic [NP*DW-1:0] d);
    upd_valid = 1; upd_row = RW'(row); upd_lane_en = m; upd_first = f; upd_data = d;
    for (int g = 0; g < NP; g++)
      if (m[g]) model[row*NP+g] = expect_entry(model[row*NP+g], d[g*DW +: DW], f);
    @(posedge clk); #1;
    upd_valid = 0;
  endtask

  // R6 R7 R8: drain with random stalls
  task automatic drain(input int cnt, input logic [AW-1:0] base);
    int nb, beat, t;
    logic exp_done, got_done, prev_v;
    logic [AW-1:0] prev_a;
    logic [DW-1:0] prev_d;
    idle(4);
    nb = (cnt > MC) ? MC : cnt;
    drain_start = 1; drain_count = CW'(cnt); drain_base = base;
    @(posedge clk); #1;
    drain_start = 0;
    beat = 0; exp_done = (nb == 0); got_done = 0; t = 0; prev_v = 0;
    prev_a = '0; prev_d = '0;
    while (!got_done && t < 2000) begin
      wr_ready = ($urandom % 10) < 6;
      #14;
      check(drain_done == exp_done, "R8 done timing", drain_done, exp_done);
      got_done = drain_done;
      exp_done = 0;
      if (prev_v)
        check(wr_valid && wr_addr == prev_a && wr_data == prev_d, "R7 stall hold",
              wr_data, prev_d);
      prev_v = 0;
      if (wr_valid) begin
        check(beat < nb, "R6 beat count", beat, nb);
        if (beat < nb) begin
          check(wr_addr == base + AW'(beat), "R6 address", wr_addr, base + AW'(beat));
          check(wr_data == model[beat], "R6 R4 entry value", wr_data, model[beat]);
        end
        if (wr_ready) begin
          beat++;
          if (beat == nb) exp_done = 1;
        end else begin
          prev_v = 1; prev_a = wr_addr; prev_d = wr_data;
        end
      end
      @(posedge clk); #1;
      t++;
    end
    wr_ready = 0;
    check(got_done && beat == nb, "R8 drain completed", beat, nb);
  endtask

  task automatic random_pixel(input logic full_first);
    int nic;
    nic = 1 + ($urandom % 5);
    for (int ic = 0; ic < nic; ic++) begin
      for (int r = 0; r < ROWS; r++) begin
        int row;
        logic [NP-1:0] m;
        logic [NP*DW-1:0] d;
        row = (ic == 0 && full_first) ? r : int'($urandom % ROWS);
        m = (ic == 0 && full_first) ? '1 : NP'($urandom);
        for (int g = 0; g < NP; g++) d[g*DW +: DW] = DW'($urandom);
        send(row, m, ic == 0, d);
        // R4: same row again with no gap, then gap 0..2
        if (ic != 0 && ($urandom % 10) < 3) begin
          for (int g = 0; g < NP; g++) d[g*DW +: DW] = DW'($urandom);
          idle($urandom % 3);
          send(row, NP'($urandom), 1'b0, d);
        end
        if (($urandom % 4) == 0) idle($urandom % 3);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < MC; i++) model[i] = '0;
    idle(3);
    #5;
    check(wr_valid == 0, "R9 reset wr_valid", wr_valid, 0);
    check(drain_done == 0, "R9 reset drain_done", drain_done, 0);
    rst_n = 1;
    idle(2);
    check(wr_valid == 0 && drain_done == 0, "R9 idle after reset", wr_valid, 0);

    // directed: fill all, R3 wrap 0x7FFF + 1, same-entry back-to-back (R4)
    for (int r = 0; r < ROWS; r++) send(r, '1, 1'b1, {NP{16'h0010}});
    send(0, 4'b0001, 1'b1, {NP{16'h7FFF}});
    send(0, 4'b0001, 1'b0, {NP{16'h0001}});
    send(1, 4'b0110, 1'b0, {NP{16'h0003}});
    send(1, 4'b0110, 1'b0, {NP{16'h0005}});
    send(1, 4'b0110, 1'b0, {NP{16'hFFFF}});
    send(2, 4'b1000, 1'b1, {NP{16'h1234}});   // R5: lanes 0..2 of row 2 keep 0x10
    drain(12, 32'h0000_1000);
    check(model[0] == 16'h8000, "R3 wrap model", model[0], 16'h8000);
    drain(0, 32'h0);                          // R8 zero count
    drain(100, 32'hFFFF_FFF0);                // R6 clamp and address wrap

    for (int p = 0; p < 6; p++) begin
      random_pixel(p == 0);
      drain(1 + int'($urandom % MC), AW'($urandom));
    end
    drain(MC, 32'h0000_8000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule